// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Port

This block sits between a 16-bit network controller and a byte-addressed memory master port. The controller hands over one transfer at a time: direction, start address, byte count and a flag that turns swapping off. The port forms the memory address by OR-ing a base value into the requested address. It then drives memory commands and moves 16-bit data beats in either direction.

In swap mode, address bit 0 and count bit 0 are cleared. The two bytes of every halfword are then exchanged, on the way to memory and on the way back. Swapped writes are cut into chunks of at most `CHUNK_BYTES` bytes, and the address steps forward by each chunk's size. In bypass mode, address, count and data pass through untouched. Reads and bypass writes go out as one command each. A single-cycle done pulse marks the end of a transfer.

Top module: `hswap_dma_port`

## Requirements
- R1: After reset the port is idle: `req_ready` is 1, and `mem_cmd_valid`, `mem_wvalid`, `rd_valid` and `done` are 0.
- R2: The command address is `req_addr | ext_base`, with `ext_base` sampled when the request is accepted.
- R3: With `req_nosw`=1, the address (after the OR) and the byte count are used unmodified, and data beats pass through unchanged in both directions.
- R4: With `req_nosw`=0, bit 0 of the formed address and bit 0 of the byte count are forced to 0 before any command is issued.
- R5: With swapping on, every write beat satisfies `mem_wdata[15:8]=wr_data[7:0]` and `mem_wdata[7:0]=wr_data[15:8]`.
- R6: With swapping on, every read beat satisfies `rd_data[15:8]=mem_rdata[7:0]` and `rd_data[7:0]=mem_rdata[15:8]`.
- R7: A swapped write issues commands of `min(remaining, CHUNK_BYTES)` bytes. Each command's address is the previous one plus the previous command's length, until the count is used up.
- R8: A read, in either mode, and a bypass write each issue exactly one command, carrying the whole formed byte count.
- R9: Each command moves exactly ceil(`mem_cmd_len`/2) data beats. A pending command holds its address and length stable until accepted.
- R10: `done` is high for exactly one cycle, in the cycle after the final data beat is accepted. `req_ready` stays 0 from acceptance until that cycle.
- R11: A request whose formed byte count is 0 issues no command and raises `done` in the cycle after acceptance. This includes a 1-byte request in swap mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_base | input | ADDR_W | Base value OR-ed into the request address |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Port idle, request accepted when valid |
| req_write | input | 1 | 1 = controller to memory, 0 = memory to controller |
| req_nosw | input | 1 | 1 = no swap, no alignment |
| req_addr | input | ADDR_W | Requested byte address |
| req_len | input | LEN_W | Requested byte count |
| wr_data | input | 16 | Write beat from controller |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat taken |
| rd_data | output | 16 | Read beat to controller |
| rd_valid | output | 1 | Read beat valid |
| rd_ready | input | 1 | Controller takes read beat |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory accepts command |
| mem_cmd_write | output | 1 | Command direction |
| mem_cmd_addr | output | ADDR_W | Command byte address |
| mem_cmd_len | output | LEN_W | Command byte count |
| mem_wdata | output | 16 | Write beat to memory |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Memory takes write beat |
| mem_rdata | input | 16 | Read beat from memory |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rready | output | 1 | Port takes read beat |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench builds the port with `ADDR_W`=16, `LEN_W`=8 and `CHUNK_BYTES`=8. A 20-byte swapped write therefore splits into 8, 8 and 4 byte commands, and a 16-byte write ends exactly on a chunk boundary, within a few dozen cycles. The small chunk also lets one test mix full and partial chunks. All memory-side and controller-side ready/valid signals stall on staggered patterns, so command hold, beat counting and done timing are exercised under back-pressure.

// File: rtl/hsw_pkg.sv
`timescale 1ns/1ps
package hsw_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CMD  = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_t;

  // Exchange the two bytes of a halfword.
  function automatic logic [15:0] swap_halves(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

endpackage

// File: rtl/hsw_lane.sv
`timescale 1ns/1ps
module hsw_lane (
  input  logic        bypass,
  input  logic [15:0] din,
  output logic [15:0] dout
);
  import hsw_pkg::*;

  always_comb begin
    dout = bypass ? din : swap_halves(din);
  end
endmodule

// File: rtl/hsw_seq.sv
`timescale 1ns/1ps
module hsw_seq #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_nosw,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] ext_base,
  output logic              req_ready,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  input  logic              beat_fire,
  output logic              in_data,
  output logic              cur_write,
  output logic              cur_nosw,
  output logic              done
);
  import hsw_pkg::*;

  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_BYTES);
  localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

  // Arithmetic kept in functions so it reads as the requirements do.
  function automatic logic [ADDR_W-1:0] form_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] base,
                                                   input logic nosw);
    logic [ADDR_W-1:0] t;
    t = a | base;
    if (!nosw) t[0] = 1'b0;
    return t;
  endfunction

  function automatic logic [LEN_W-1:0] form_len(input logic [LEN_W-1:0] l,
                                                 input logic nosw);
    logic [LEN_W-1:0] t;
    t = l;
    if (!nosw) t[0] = 1'b0;
    return t;
  endfunction

  function automatic logic [LEN_W-1:0] pick_chunk(input logic [LEN_W-1:0] rem,
                                                   input logic wr,
                                                   input logic nosw);
    if (wr && !nosw && (rem > CHUNK_L)) return CHUNK_L;
    return rem;
  endfunction

  function automatic logic [LEN_W-1:0] beats_of(input logic [LEN_W-1:0] l);
    return (l >> 1) + {{(LEN_W-1){1'b0}}, l[0]};
  endfunction

  seq_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  chunk_q;
  logic [LEN_W-1:0]  beats_q;
  logic              wr_q;
  logic              nosw_q;
  logic              done_q;

  // Named internal events
  logic              ev_req_take;
  logic              ev_zero;
  logic              ev_cmd_take;
  logic              ev_beat;
  logic              ev_last;
  logic [LEN_W-1:0]  eff_len;
  logic [LEN_W-1:0]  rem_after;

  assign eff_len     = form_len(req_len, req_nosw);
  assign ev_req_take = req_valid && (st == SEQ_IDLE);
  assign ev_zero     = ev_req_take && (eff_len == '0);
  assign ev_cmd_take = (st == SEQ_CMD) && cmd_ready;
  assign ev_beat     = (st == SEQ_DATA) && beat_fire;
  assign ev_last     = ev_beat && (beats_q == ONE_L);
  assign rem_after   = rem_q - chunk_q;

  assign req_ready = (st == SEQ_IDLE);
  assign cmd_valid = (st == SEQ_CMD);
  assign cmd_write = wr_q;
  assign cmd_addr  = addr_q;
  assign cmd_len   = pick_chunk(rem_q, wr_q, nosw_q);
  assign in_data   = (st == SEQ_DATA);
  assign cur_write = wr_q;
  assign cur_nosw  = nosw_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      beats_q <= '0;
      wr_q    <= 1'b0;
      nosw_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        SEQ_IDLE: if (ev_req_take) begin
          addr_q <= form_addr(req_addr, ext_base, req_nosw);
          rem_q  <= eff_len;
          wr_q   <= req_write;
          nosw_q <= req_nosw;
          if (ev_zero) done_q <= 1'b1;
          else         st     <= SEQ_CMD;
        end
        SEQ_CMD: if (ev_cmd_take) begin
          chunk_q <= cmd_len;
          beats_q <= beats_of(cmd_len);
          st      <= SEQ_DATA;
        end
        SEQ_DATA: if (ev_beat) begin
          beats_q <= beats_q - ONE_L;
          if (ev_last) begin
            addr_q <= addr_q + ADDR_W'(chunk_q);
            rem_q  <= rem_after;
            if (rem_after == '0) begin
              st     <= SEQ_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= SEQ_CMD;
            end
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // Alignment of every command issued in swap mode
  assert_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !nosw_q) |-> (cmd_addr[0] == 1'b0 && cmd_len[0] == 1'b0));

  // Swapped write chunks never exceed the bound and are never empty
  assert_chunk_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wr_q && !nosw_q) |-> (cmd_len <= CHUNK_L && cmd_len != '0));

  // A stalled command holds still
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));

  // Completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Last beat of last chunk completes on the next cycle
  assert_last_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last && rem_after == '0) |=> (done && req_ready));

  // Zero effective length completes without a command
  assert_zero_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> (done && !cmd_valid));
endmodule

// File: rtl/hswap_dma_port.sv
`timescale 1ns/1ps
module hswap_dma_port #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_nosw,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [15:0]       wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [LEN_W-1:0]  mem_cmd_len,
  output logic [15:0]       mem_wdata,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_rvalid,
  output logic              mem_rready,
  output logic              done
);
  logic in_data, cur_write, cur_nosw, beat_fire;
  logic wr_phase, rd_phase;

  assign wr_phase  = in_data && cur_write;
  assign rd_phase  = in_data && !cur_write;

  assign mem_wvalid = wr_valid && wr_phase;
  assign wr_ready   = mem_wready && wr_phase;
  assign rd_valid   = mem_rvalid && rd_phase;
  assign mem_rready = rd_ready && rd_phase;
  assign beat_fire  = cur_write ? (wr_valid && mem_wready) : (mem_rvalid && rd_ready);

  hsw_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_nosw(req_nosw),
    .req_addr(req_addr), .req_len(req_len), .ext_base(ext_base),
    .req_ready(req_ready),
    .cmd_valid(mem_cmd_valid), .cmd_ready(mem_cmd_ready),
    .cmd_write(mem_cmd_write), .cmd_addr(mem_cmd_addr), .cmd_len(mem_cmd_len),
    .beat_fire(beat_fire), .in_data(in_data),
    .cur_write(cur_write), .cur_nosw(cur_nosw), .done(done)
  );

  hsw_lane u_wr_lane (.bypass(cur_nosw), .din(wr_data),   .dout(mem_wdata));
  hsw_lane u_rd_lane (.bypass(cur_nosw), .din(mem_rdata), .dout(rd_data));

  // Write beats reach memory only when the controller offers one
  assert_wbeat_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (wr_valid && mem_cmd_write && !mem_cmd_valid));

  // Read beats reach the controller only when memory returns one
  assert_rbeat_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_rvalid && !req_ready));
endmodule

// File: tb/hswap_dma_port_tb_top.sv
`timescale 1ns/1ps
module hswap_dma_port_tb_top;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int CB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_base = '0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_nosw = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [15:0]   wr_data = '0;
  logic          wr_valid = 1'b0, rd_ready = 1'b0;
  logic          mem_cmd_ready = 1'b0, mem_wready = 1'b0, mem_rvalid = 1'b0;
  logic [15:0]   mem_rdata = '0;
  logic          req_ready, wr_ready, rd_valid, mem_cmd_valid, mem_cmd_write;
  logic [15:0]   rd_data, mem_wdata;
  logic [AW-1:0] mem_cmd_addr;
  logic [LW-1:0] mem_cmd_len;
  logic          mem_wvalid, mem_rready, done;

  hswap_dma_port #(.ADDR_W(AW), .LEN_W(LW), .CHUNK_BYTES(CB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_base(ext_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_nosw(req_nosw), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_len(mem_cmd_len), .mem_wdata(mem_wdata), .mem_wvalid(mem_wvalid),
    .mem_wready(mem_wready), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .mem_rready(mem_rready), .done(done)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit active   = 1'b0;
  bit busy     = 1'b0;
  bit done_flag = 1'b0;
  string tag   = "R1";

  logic [AW+LW:0] exp_cmd_q[$];
  logic [15:0]    exp_wd_q[$];
  logic [15:0]    exp_rd_q[$];
  logic [15:0]    src_q[$];
  logic [15:0]    resp_q[$];

  function automatic logic [15:0] bsw(input logic [15:0] v);
    return 16'((v << 8) | (v >> 8));
  endfunction

  function automatic logic [15:0] rdpat(input logic [AW-1:0] a);
    return 16'(a) ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected < %0d", cyc, 50000);
        summary();
      end
    end
  end

  // Memory model, controller data side and monitor
  initial begin
    forever begin
      @(negedge clk);
      mem_cmd_ready = (cyc % 3) != 1;
      mem_wready    = (cyc % 4) != 2;
      rd_ready      = (cyc % 5) != 3;
      mem_rvalid    = (resp_q.size() > 0) && ((cyc % 3) != 2);
      mem_rdata     = (resp_q.size() > 0) ? resp_q[0] : 16'h0;
      wr_valid      = (src_q.size() > 0) && ((cyc % 7) != 5);
      wr_data       = (src_q.size() > 0) ? src_q[0] : 16'h0;
      #5;
      if (active) begin
        if (mem_cmd_valid && mem_cmd_ready) begin
          if (exp_cmd_q.size() == 0) begin
            check(1'b0, tag, "unexpected command", {7'd0, mem_cmd_write, mem_cmd_addr, mem_cmd_len}, 32'h0);
          end else begin
            logic [AW+LW:0] e;
            e = exp_cmd_q.pop_front();
            check({mem_cmd_write, mem_cmd_addr, mem_cmd_len} == e, tag, "command {wr,addr,len}",
                  {7'd0, mem_cmd_write, mem_cmd_addr, mem_cmd_len}, {7'd0, e});
          end
          if (!mem_cmd_write) begin
            for (int k = 0; k < (int'(mem_cmd_len) + 1) / 2; k++)
              resp_q.push_back(rdpat(mem_cmd_addr + AW'(2 * k)));
          end
        end
        if (mem_wvalid && mem_wready) begin
          if (exp_wd_q.size() == 0) check(1'b0, "R9", "extra write beat", {16'h0, mem_wdata}, 32'h0);
          else begin
            logic [15:0] e;
            e = exp_wd_q.pop_front();
            check(mem_wdata == e, tag, "write beat", {16'h0, mem_wdata}, {16'h0, e});
          end
        end
        if (rd_valid && rd_ready) begin
          if (exp_rd_q.size() == 0) check(1'b0, "R9", "extra read beat", {16'h0, rd_data}, 32'h0);
          else begin
            logic [15:0] e;
            e = exp_rd_q.pop_front();
            check(rd_data == e, tag, "read beat", {16'h0, rd_data}, {16'h0, e});
          end
        end
        if (busy && !done)
          check(req_ready == 1'b0, "R10", "req_ready while busy", {31'd0, req_ready}, 32'h0);
        if (done) begin
          check(busy, "R10", "done without pending transfer", {31'd0, done}, {31'd0, busy});
          done_flag = 1'b1;
        end
      end
      if (wr_valid && wr_ready) void'(src_q.pop_front());
      if (mem_rvalid && mem_rready) void'(resp_q.pop_front());
    end
  end

  task automatic xfer(input string t, input bit wr, input bit nosw,
                      input logic [AW-1:0] base, input logic [AW-1:0] a,
                      input logic [LW-1:0] l);
    logic [AW-1:0] ea;
    logic [LW-1:0] el;
    int nb;
    tag = t;
    ea = a | base;
    el = l;
    if (!nosw) begin
      ea = ea & ~AW'(1);
      el = el & ~LW'(1);
    end
    if (el != 0) begin
      if (wr && !nosw) begin
        int rem;
        logic [AW-1:0] ca;
        rem = int'(el);
        ca  = ea;
        while (rem > 0) begin
          int c;
          c = (rem > CB) ? CB : rem;
          exp_cmd_q.push_back({1'b1, ca, LW'(c)});
          ca  = ca + AW'(c);
          rem = rem - c;
        end
      end else begin
        exp_cmd_q.push_back({wr, ea, el});
      end
    end
    nb = (int'(el) + 1) / 2;
    for (int k = 0; k < nb; k++) begin
      if (wr) begin
        logic [15:0] v;
        v = {a[7:0] ^ 8'(k * 17), 8'(k + 8'h31)};
        src_q.push_back(v);
        exp_wd_q.push_back(nosw ? v : bsw(v));
      end else begin
        logic [15:0] v;
        v = rdpat(ea + AW'(2 * k));
        exp_rd_q.push_back(nosw ? v : bsw(v));
      end
    end
    @(negedge clk);
    ext_base  = base;
    req_write = wr;
    req_nosw  = nosw;
    req_addr  = a;
    req_len   = l;
    req_valid = 1'b1;
    #5;
    while (!req_ready) begin
      @(negedge clk);
      #5;
    end
    @(negedge clk);
    req_valid = 1'b0;
    busy      = 1'b1;
    wait (done_flag);
    done_flag = 1'b0;
    busy      = 1'b0;
    check(exp_cmd_q.size() == 0, "R9", {t, " commands left at done"}, exp_cmd_q.size(), 0);
    check(exp_wd_q.size() == 0 && exp_rd_q.size() == 0, "R10",
          {t, " beats left at done"}, exp_wd_q.size() + exp_rd_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(req_ready == 1'b1, "R1", "reset req_ready", {31'd0, req_ready}, 1);
    check(!mem_cmd_valid && !mem_wvalid && !rd_valid, "R1", "reset valids",
          {29'd0, mem_cmd_valid, mem_wvalid, rd_valid}, 0);
    check(done == 1'b0, "R1", "reset done", {31'd0, done}, 0);
    active = 1'b1;

    // Swapped write, odd address and length, OR of base
    xfer("R2 R4 R5", 1'b1, 1'b0, 16'h2000, 16'h0101, 8'd7);
    // Swapped write spanning several chunks with a partial tail
    xfer("R7 R5", 1'b1, 1'b0, 16'h0400, 16'h0041, 8'd20);
    // Swapped write ending exactly on a chunk boundary
    xfer("R7 R9", 1'b1, 1'b0, 16'h0000, 16'h1230, 8'd16);
    // Bypass write, odd address and odd length, single command
    xfer("R3 R8", 1'b1, 1'b1, 16'h8000, 16'h0033, 8'd5);
    // Bypass write longer than a chunk stays one command
    xfer("R3 R8", 1'b1, 1'b1, 16'h0000, 16'h0700, 8'd22);
    // Swapped read, not chunked
    xfer("R6 R8", 1'b0, 1'b0, 16'h0010, 16'h0203, 8'd19);
    // Bypass read with odd length
    xfer("R3 R9", 1'b0, 1'b1, 16'h4000, 16'h0055, 8'd3);
    // Zero-length and rounded-to-zero requests
    xfer("R11", 1'b1, 1'b0, 16'h0000, 16'h0100, 8'd1);
    xfer("R11", 1'b0, 1'b1, 16'h0000, 16'h0100, 8'd0);
    xfer("R11", 1'b0, 1'b0, 16'h0000, 16'h0100, 8'd1);
    // Back-to-back after zero-length
    xfer("R2 R6", 1'b0, 1'b0, 16'h0F00, 16'h00F1, 8'd4);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule